// File: doc/BRIEF.md
# Phase Frequency Window Detector

This block sorts the frequency of an alternator's digitised phase signal into one of three speed zones. It uses the PWM base period as its time unit. Time is measured with a strobe that runs at eight times the PWM base rate. The block counts these strobes between consecutive rising edges of the phase signal, and so obtains the phase period in eighths of a base period.

There are two output flags, and control-mode selection uses them:

- The slow flag is raised when the phase frequency falls below one eighth of the base rate. This indicates a stalled engine or a slipping belt.
- The fast flag is raised when the phase frequency rises above three quarters of the base rate.

When neither flag is set, the phase frequency lies between the two thresholds. In that window the slow digital duty-cycle control stays in charge. Above the upper threshold, the ramp-compare PWM takes over.

Both thresholds are fixed ratios of the base rate. They therefore follow the oscillator without any calibration.

The phase input arrives asynchronously, and a flop chain brings it into the clock domain. The flags change state only when a measurement completes on a rising edge, or when the period counter saturates because no edge has arrived.

Top module: `phase_window_det`

## Requirements
- R1: During and after reset, slow_o is 1 and fast_o is 0, and no measurement is armed.
- R2: phase_async_i passes through two synchronising flops. Only its rising edges define the period, so neither the high time nor a falling edge changes the result.
- R3: The measured period is the number of cycles with tick_8x_i high between two successive synchronised rising edges. The count restarts on each rising edge, and a strobe in the edge cycle counts toward the next period.
- R4: After a completed measurement, slow_o is 1 when the period exceeds 64 strobes. A period of 64 gives 0 and a period of 65 gives 1.
- R5: After a completed measurement, fast_o is 1 when three times the period is below 32 strobes. A period of 10 gives 1 and a period of 11 gives 0.
- R6: For periods from 11 to 64 strobes inclusive, both flags are 0.
- R7: The first rising edge after reset only starts a measurement, and the flags keep their reset values.
- R8: If the period counter reaches its saturation value of 255 with no rising edge, slow_o becomes 1 and fast_o becomes 0.
- R9: The flags hold their values in every cycle that has neither a rising edge nor a saturated counter.
- R10: slow_o and fast_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_8x_i | input | 1 | One-cycle strobe at eight times the PWM base rate |
| phase_async_i | input | 1 | Digitised stator phase level, asynchronous |
| slow_o | output | 1 | Phase frequency below one eighth of the base rate |
| fast_o | output | 1 | Phase frequency above three quarters of the base rate |

## Verification
On every cycle the bound checker checks four things:

- the two flags are never set together;
- the flags hold still between events;
- the counter advances by one per strobe, restarts on an edge and sticks at saturation;
- a saturated counter forces the slow state, and an unarmed detector shows the reset flags.

The placement of the thresholds can only be shown by the bench's scenarios. These drive exact phase periods across both boundaries (64/65 and 10/11), change the duty of the phase waveform, wait long enough to trigger a timeout and then recover from it, and arm again after a reset in mid-run.

// File: rtl/pfw_pkg.sv
// Package: shared defaults and the flag pair type for the phase
// frequency window detector.
package pfw_pkg;

    // Default period counter width (saturates at 2**width - 1).
    localparam int PFW_CNT_W     = 8;
    // Period above this many 8x strobes means "slow".
    localparam int PFW_LOW_LIMIT = 64;
    // fast when PFW_HIGH_MUL * period < PFW_HIGH_NUM.
    localparam int PFW_HIGH_MUL  = 3;
    localparam int PFW_HIGH_NUM  = 32;

    // Speed flag pair produced by the classifier.
    typedef struct packed {
        logic slow;
        logic fast;
    } pfw_flags_t;

endpackage

// File: rtl/pfw_sync.sv
// Module: pfw_sync
// Brings the asynchronous phase level into the clock domain through a
// STAGES-deep flop chain. It then flags a rising edge for one cycle.
// Assumes STAGES >= 2. The edge pulse lags the input by STAGES cycles.
module pfw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_async_i,
    output logic rise_o
);

    // One extra flop beyond the synchroniser holds the previous level.
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the phase level through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], phase_async_i};
        end
    end

    // Rising edge: synchronised level high, previous level low.
    always_comb begin
        rise_o = chain_q[LAST-1] & ~chain_q[LAST];
    end

endmodule

// File: rtl/pfw_period_counter.sv
// Module: pfw_period_counter
// Counts the 8x strobes since the last rising phase edge. It restarts on
// each edge, and a strobe in the edge cycle counts as the first of the
// new period. The count saturates at its all-ones value, which the block
// treats as a timeout. Assumes tick_i is a one-cycle strobe.
module pfw_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Restart on an edge, otherwise count strobes up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            cnt_q <= tick_i ? CNT_ONE : '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Expose the running count and the saturation (timeout) condition.
    always_comb begin
        cnt_o = cnt_q;
        sat_o = (cnt_q == CNT_MAX);
    end

endmodule

// File: rtl/pfw_classifier.sv
// Module: pfw_classifier
// Sets the speed flags from a completed period measurement. It ignores
// the first edge after reset, which only arms the measurement. When the
// counter saturates it forces the slow state. The flags hold otherwise.
// Assumes LOW_LIMIT is below the saturation value of the counter.
module pfw_classifier
    import pfw_pkg::*;
#(
    parameter int CNT_W     = PFW_CNT_W,
    parameter int LOW_LIMIT = PFW_LOW_LIMIT,
    parameter int HIGH_MUL  = PFW_HIGH_MUL,
    parameter int HIGH_NUM  = PFW_HIGH_NUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             sat_i,
    input  logic [CNT_W-1:0] meas_i,
    output logic             armed_o,
    output pfw_flags_t       flags_o
);

    // Product width leaves room for a multiplier of up to 15.
    localparam int PW = CNT_W + 4;
    localparam logic [CNT_W-1:0] LOW_CMP  = CNT_W'(LOW_LIMIT);
    localparam logic [PW-1:0]    MUL_VAL  = PW'(HIGH_MUL);
    localparam logic [PW-1:0]    HIGH_CMP = PW'(HIGH_NUM);
    localparam pfw_flags_t       FLAGS_RST = '{slow: 1'b1, fast: 1'b0};

    logic [PW-1:0] scaled;
    pfw_flags_t    next_cls;
    pfw_flags_t    flags_q;
    logic          armed_q;

    // Classify the measured period against both thresholds.
    always_comb begin
        scaled        = PW'(meas_i) * MUL_VAL;
        next_cls.slow = (meas_i > LOW_CMP);
        next_cls.fast = (scaled < HIGH_CMP);
    end

    // Update the flags on an armed edge or on a timeout, and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            flags_q <= FLAGS_RST;
        end else if (rise_i) begin
            armed_q <= 1'b1;
            if (armed_q) begin
                flags_q <= next_cls;
            end
        end else if (sat_i) begin
            flags_q <= FLAGS_RST;
        end
    end

    // Drive the registered results out.
    always_comb begin
        armed_o = armed_q;
        flags_o = flags_q;
    end

endmodule

// File: rtl/phase_window_det.sv
// Module: phase_window_det (top)
// Measures the period of a digitised stator phase signal in 8x base-rate
// strobes. It raises slow_o below one eighth of the base rate and fast_o
// above three quarters of it. Assumes tick_8x_i is a one-cycle strobe and
// that phase_async_i may change at any time.
module phase_window_det
    import pfw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = PFW_CNT_W,
    parameter int LOW_LIMIT   = PFW_LOW_LIMIT,
    parameter int HIGH_MUL    = PFW_HIGH_MUL,
    parameter int HIGH_NUM    = PFW_HIGH_NUM
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_8x_i,
    input  logic phase_async_i,
    output logic slow_o,
    output logic fast_o
);

    logic             rise_evt;
    logic             cnt_sat;
    logic             armed;
    logic [CNT_W-1:0] period_cnt;
    pfw_flags_t       flags;

    pfw_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_async_i (phase_async_i),
        .rise_o        (rise_evt)
    );

    pfw_period_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_8x_i),
        .rise_i (rise_evt),
        .cnt_o  (period_cnt),
        .sat_o  (cnt_sat)
    );

    pfw_classifier #(
        .CNT_W     (CNT_W),
        .LOW_LIMIT (LOW_LIMIT),
        .HIGH_MUL  (HIGH_MUL),
        .HIGH_NUM  (HIGH_NUM)
    ) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_evt),
        .sat_i   (cnt_sat),
        .meas_i  (period_cnt),
        .armed_o (armed),
        .flags_o (flags)
    );

    // Split the flag pair onto the output ports.
    always_comb begin
        slow_o = flags.slow;
        fast_o = flags.fast;
    end

endmodule

// File: rtl/pfw_checker.sv
// Module: pfw_checker
// Cycle-level properties of phase_window_det. It is attached to the top
// with the bind statement at the end of this file.
module pfw_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             rise_i,
    input logic             sat_i,
    input logic             armed_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             slow_i,
    input logic             fast_i
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R10: the two zones exclude each other.
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(slow_i && fast_i));

    // R9: without an edge or a timeout, the flags keep their values.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !sat_i) |=> ($stable(slow_i) && $stable(fast_i)));

    // R8: a saturated counter with no edge forces the slow state.
    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && !rise_i) |=> (slow_i && !fast_i));

    // R8: a saturated counter stays saturated until an edge arrives.
    p_sat_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && !rise_i) |=> sat_i);

    // R3: each strobe advances the count by exactly one.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !rise_i && !sat_i) |=> (cnt_i == $past(cnt_i) + ONE));

    // R3: an edge restarts the count at zero or one.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (cnt_i <= ONE));

    // R7: while no measurement is armed, the reset flags are shown.
    p_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |-> (slow_i && !fast_i));

endmodule

bind phase_window_det pfw_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_8x_i),
    .rise_i  (rise_evt),
    .sat_i   (cnt_sat),
    .armed_i (armed),
    .cnt_i   (period_cnt),
    .slow_i  (slow_o),
    .fast_i  (fast_o)
);

// File: tb/phase_window_det_tb.sv
module phase_window_det_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NVEC       = 9;

    // Columns: period in strobes, high time in strobes, expected slow, expected fast.
    localparam int VECS [NVEC][4] = '{
        '{5,   2,  0, 1},   // R5 deep fast
        '{10,  5,  0, 1},   // R5 boundary, fast
        '{11,  5,  0, 0},   // R5/R6 boundary, not fast
        '{40,  20, 0, 0},   // R6 mid window
        '{64,  32, 0, 0},   // R4 boundary, not slow
        '{65,  32, 1, 0},   // R4 boundary, slow
        '{100, 1,  1, 0},   // R2 narrow high pulse
        '{8,   7,  0, 1},   // R2 wide high pulse
        '{30,  1,  0, 0}    // R6 narrow pulse in window
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic phase = 1'b0;
    logic slow, fast;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    phase_window_det u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_8x_i     (tick),
        .phase_async_i (phase),
        .slow_o        (slow),
        .fast_o        (fast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe generator: one cycle high every TICK_DIV cycles.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick = (div == TICK_DIV - 1);
            div = (div + 1) % TICK_DIV;
        end
    end

    task automatic check(input logic exp_slow, input logic exp_fast, input string req);
        n_checks++;
        if (slow !== exp_slow || fast !== exp_fast) begin
            n_errors++;
            $display("FAIL %s: slow/fast = %b%b, expected %b%b", req, slow, fast, exp_slow, exp_fast);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    // Drive reps phase periods of len strobes, high for hi strobes each.
    task automatic drive_periods(input int len, input int hi, input int reps);
        for (int r = 0; r < reps; r++) begin
            phase = 1'b1;
            wait_ticks(hi);
            phase = 1'b0;
            wait_ticks(len - hi);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase = 1'b0;
        repeat (5) @(negedge clk);
        check(1'b1, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(1'b1, 1'b0, "R1 after reset release");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R7: the first edge only arms, even for a short interval.
        drive_periods(5, 2, 1);
        check(1'b1, 1'b0, "R7 first edge arms only");

        // Table walk: three periods each, then check the settled flags.
        for (int i = 0; i < NVEC; i++) begin
            drive_periods(VECS[i][0], VECS[i][1], 3);
            check(VECS[i][2][0], VECS[i][3][0],
                  $sformatf("R3 period %0d strobes", VECS[i][0]));
        end

        // R9: a long quiet stretch short of saturation leaves the flags as they were.
        wait_ticks(150);
        check(1'b0, 1'b0, "R9 hold without edge");

        // R8: saturation forces the slow state.
        wait_ticks(120);
        check(1'b1, 1'b0, "R8 timeout");

        // R8: the first edge after a timeout measures a saturated period.
        drive_periods(5, 2, 1);
        check(1'b1, 1'b0, "R8 edge after timeout");
        drive_periods(5, 2, 2);
        check(1'b0, 1'b1, "R3 recovery to fast");

        // R1/R7: a reset in mid-run restores the reset flags and disarms.
        do_reset();
        drive_periods(5, 2, 1);
        check(1'b1, 1'b0, "R7 rearm after reset");
        drive_periods(40, 3, 2);
        check(1'b0, 1'b0, "R6 window after rearm");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule